// File: doc/BRIEF.md
# Reload Toggle Timer

This block is a down-counting system timer with automatic reload. Its counter moves only on cycles where the `tick` enable is high; `tick` stands in for whatever divided timer clock the surrounding chip provides. When a tick arrives while the count is already zero, the counter takes the value held in a software-written reload register and carries on counting down from there. The counter never stops, so a constant reload value gives a fixed period with no further software action.

Each underflow can invert a square-wave output pin. This only happens while the output-enable input is high. With a constant reload value of N, each output level lasts N+1 ticks, which gives a 50% duty-cycle wave. When the output goes from low to high, a sticky pending flag is set. An interrupt request is raised while that flag is set and the interrupt-enable input is high. The flag is therefore set once per full output period, not on every underflow. Software clears the flag with a one-cycle strobe.

Top module: `reload_toggle_timer`

## Requirements
- R1: After reset, `wave_out` and `irq` are low, the counter holds FFFFh and the reload register holds FFFFh. The first underflow therefore happens on the 65536th tick after reset.
- R2: On a cycle where `tick` is low, the counter, `wave_out` and the pending flag hold their values. On a cycle where `tick` is high and the count is not zero, the count decreases by one.
- R3: An underflow is a cycle where `tick` is high and the count is 0000h. On that edge the counter loads the reload register, so underflows are reload+1 ticks apart.
- R4: A cycle with `rld_we` high stores `rld_wdata` into the reload register at that edge. The write does not change the running count. The new value is used from the next underflow on. If the write falls in an underflow cycle, the counter loads the value the reload register held before the write.
- R5: While `out_en` is high, `wave_out` inverts on every underflow. While `out_en` is low, `wave_out` keeps its level and the counter keeps running.
- R6: With a constant reload value N and `out_en` high, `wave_out` stays high for N+1 ticks and then low for N+1 ticks.
- R7: The pending flag is set on the edge where `wave_out` goes from 0 to 1. A 1-to-0 toggle does not set it.
- R8: `irq` is high exactly while the pending flag is set and `irq_en` is high, in the same cycle. `irq_en` never changes the pending flag.
- R9: The pending flag stays set until a cycle with `pend_clr` high clears it at that edge. If a rising toggle occurs in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per timer clock period |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W (16) | Reload value to store |
| out_en | input | 1 | Allows `wave_out` to toggle on underflow |
| irq_en | input | 1 | Lets the pending flag drive `irq` |
| pend_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| wave_out | output | 1 | Square-wave output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and settles well before the rising edge. They also treat `tick`, `rld_we` and `pend_clr` as level-sampled strobes that count once for each edge they are high. The bench respects this by changing every input only on the falling edge and by holding each strobe for whole cycles. The assertions place no limit on how often `tick` arrives, so the stimulus uses continuous ticks, long gaps and writes that land exactly on an underflow.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

   // Single-cycle events passed between the timer stages.
   typedef struct packed {
      logic uflow;   // tick while the count is zero
      logic rise;    // wave_out going from 0 to 1 at this edge
   } rtt_evt_t;

   localparam int unsigned RTT_MIN_W = 2;
   localparam int unsigned RTT_MAX_W = 32;

endpackage

// File: rtl/rtt_reload_reg.sv
module rtt_reload_reg #(
   parameter int unsigned   CNT_W   = 16,
   parameter logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] value
);

   logic [CNT_W-1:0] value_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= RST_VAL;
      end else if (we) begin
         value_q <= wdata;
      end
   end

   assign value = value_q;

   // R4: a write lands one edge later; without a write the value holds
   assert_reload_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> value_q == $past(wdata));
   assert_reload_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(value_q));

endmodule

// File: rtl/rtt_downcnt.sv
module rtt_downcnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] rld_val,
   output logic             uflow
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_RST  = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             at_zero;

   assign at_zero = (cnt_q == CNT_ZERO);
   assign uflow   = tick && at_zero;

   always_comb begin
      cnt_d = cnt_q;
      if (tick) begin
         if (at_zero) begin
            cnt_d = rld_val;
         end else begin
            cnt_d = cnt_q - CNT_ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_RST;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   // R2: no tick, no movement; a tick on a nonzero count steps down by one
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q != CNT_ZERO) |=> cnt_q == $past(cnt_q) - CNT_ONE);
   // R3/R4: an underflow loads whatever the reload register held at that edge
   assert_reload_on_uflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q == CNT_ZERO) |=> cnt_q == $past(rld_val));

endmodule

// File: rtl/rtt_toggle.sv
module rtt_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic uflow,
   input  logic out_en,
   output logic wave,
   output logic rise
);

   logic wave_q;
   logic flip;

   assign flip = uflow && out_en;
   assign rise = flip && !wave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (flip) begin
         wave_q <= !wave_q;
      end
   end

   assign wave = wave_q;

   // R5: the pin moves only on an enabled underflow, and then always moves
   assert_wave_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(uflow && out_en) |=> $stable(wave_q));
   assert_wave_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && out_en) |=> wave_q != $past(wave_q));

endmodule

// File: rtl/rtt_pend_irq.sv
module rtt_pend_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic clr,
   input  logic irq_en,
   output logic irq
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (rise) begin
         pend_q <= 1'b1;
      end else if (clr) begin
         pend_q <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= pend_q && irq_en;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = pend_q && irq_en;
      end
   endgenerate

   // R7: a rising toggle always leaves the flag set; nothing else sets it
   assert_pend_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> pend_q);
   assert_pend_only_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> !$rose(pend_q));
   // R9: sticky until a clear strobe arrives
   assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr) |=> pend_q);
   assert_pend_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !rise) |=> !pend_q);

endmodule

// File: rtl/reload_toggle_timer.sv
module reload_toggle_timer
   import rtt_pkg::*;
#(
   parameter int unsigned      CNT_W      = 16,
   parameter logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}},
   parameter bit               IRQ_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rld_we,
   input  logic [CNT_W-1:0] rld_wdata,
   input  logic             out_en,
   input  logic             irq_en,
   input  logic             pend_clr,
   output logic             wave_out,
   output logic             irq
);

   generate
      if (CNT_W < RTT_MIN_W || CNT_W > RTT_MAX_W) begin : g_bad_width
         $error("reload_toggle_timer: CNT_W out of supported range");
      end
   endgenerate

   logic [CNT_W-1:0] rld_val;
   rtt_evt_t         evt;

   rtt_reload_reg #(
      .CNT_W   (CNT_W),
      .RST_VAL (RELOAD_RST)
   ) u_rld (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rld_we),
      .wdata (rld_wdata),
      .value (rld_val)
   );

   rtt_downcnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .rld_val (rld_val),
      .uflow   (evt.uflow)
   );

   rtt_toggle u_tgl (
      .clk    (clk),
      .rst_n  (rst_n),
      .uflow  (evt.uflow),
      .out_en (out_en),
      .wave   (wave_out),
      .rise   (evt.rise)
   );

   rtt_pend_irq #(
      .IRQ_REG (IRQ_REG)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (evt.rise),
      .clr    (pend_clr),
      .irq_en (irq_en),
      .irq    (irq)
   );

   // R8: with the request unmasked, a fresh rising toggle is visible on irq
   generate
      if (!IRQ_REG) begin : g_irq_chk
         assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(wave_out) && irq_en) |-> irq);
      end
   endgenerate

endmodule

// File: tb/sim_reload_toggle_timer.sv
module sim_reload_toggle_timer;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick, rld_we, out_en, irq_en, pend_clr;
   logic [15:0] rld_wdata;
   logic        wave_out, irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   reload_toggle_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rld_we(rld_we),
      .rld_wdata(rld_wdata), .out_en(out_en), .irq_en(irq_en),
      .pend_clr(pend_clr), .wave_out(wave_out), .irq(irq)
   );

   // Reference model written from the requirements
   logic [15:0] m_cnt, m_rld;
   logic        m_wave, m_pend;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 16'hFFFF; m_rld <= 16'hFFFF; m_wave <= 1'b0; m_pend <= 1'b0;
      end else begin
         if (tick) begin
            if (m_cnt == 16'h0000) begin
               m_cnt <= m_rld;
               if (out_en) m_wave <= ~m_wave;
            end else begin
               m_cnt <= m_cnt - 16'h0001;
            end
         end
         if (tick && m_cnt == 16'h0000 && out_en && !m_wave) m_pend <= 1'b1;
         else if (pend_clr) m_pend <= 1'b0;
         if (rld_we) m_rld <= rld_wdata;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic step_cmp(input string req);
      step();
      chk(req, "wave vs model", int'(wave_out), int'(m_wave));
      chk(req, "irq vs model", int'(irq), int'(m_pend & irq_en));
   endtask

   // ticks until wave_out changes, bounded
   task automatic half_len(output int n);
      logic w;
      w = wave_out;
      n = 0;
      do begin
         step();
         n++;
      end while (wave_out == w && n < 100);
   endtask

   task automatic t_reset();
      chk("R1", "wave after reset", int'(wave_out), 0);
      chk("R1", "irq after reset", int'(irq), 0);
   endtask

   task automatic t_first_underflow();
      out_en = 1'b1; irq_en = 1'b1;
      rld_we = 1'b1; rld_wdata = 16'd3;
      step();
      rld_we = 1'b0;
      tick = 1'b1;
      repeat (65535) step();
      chk("R1", "wave before 65536th tick", int'(wave_out), 0);
      chk("R3", "irq before first underflow", int'(irq), 0);
      step();
      chk("R3", "wave at first underflow", int'(wave_out), 1);
      chk("R7", "irq after rising toggle", int'(irq), 1);
   endtask

   task automatic t_clear();
      tick = 1'b0; pend_clr = 1'b1;
      step();
      pend_clr = 1'b0;
      chk("R9", "irq after clear", int'(irq), 0);
      chk("R2", "wave held without tick", int'(wave_out), 1);
   endtask

   task automatic t_duty();
      int n;
      tick = 1'b1;
      half_len(n);
      chk("R6", "high half length", n, 4);
      chk("R7", "no pend on falling toggle", int'(irq), 0);
      half_len(n);
      chk("R6", "low half length", n, 4);
      chk("R7", "pend on rising toggle", int'(irq), 1);
   endtask

   task automatic t_gate();
      logic w;
      tick = 1'b0;
      w = wave_out;
      repeat (20) step();
      chk("R2", "wave during tick gap", int'(wave_out), int'(w));
      tick = 1'b1;
      repeat (10) step_cmp("R2");
   endtask

   task automatic t_irq_en();
      tick = 1'b0;
      irq_en = 1'b0;
      step();
      chk("R8", "irq masked", int'(irq), 0);
      irq_en = 1'b1;
      step();
      chk("R8", "pend kept while masked", int'(irq), 1);
   endtask

   task automatic t_freeze();
      logic w;
      tick = 1'b0; pend_clr = 1'b1;
      step();
      pend_clr = 1'b0;
      tick = 1'b1; out_en = 1'b0;
      w = wave_out;
      repeat (11) step();
      chk("R5", "wave frozen", int'(wave_out), int'(w));
      chk("R7", "no pend while frozen", int'(irq), 0);
      out_en = 1'b1;
      repeat (12) step_cmp("R5");
   endtask

   task automatic t_set_wins();
      int guard;
      tick = 1'b0; pend_clr = 1'b1;
      step();
      pend_clr = 1'b0;
      chk("R9", "cleared before race", int'(irq), 0);
      tick = 1'b1;
      guard = 0;
      while (!(m_cnt == 16'h0000 && !m_wave) && guard < 100) begin
         step();
         guard++;
      end
      pend_clr = 1'b1;
      step();
      pend_clr = 1'b0;
      chk("R9", "set wins over clear", int'(irq), 1);
      chk("R5", "wave rose in race cycle", int'(wave_out), 1);
   endtask

   task automatic t_reload();
      int n, guard;
      tick = 1'b1;
      guard = 0;
      while (m_cnt != 16'd2 && guard < 100) begin
         step();
         guard++;
      end
      rld_we = 1'b1; rld_wdata = 16'd1;
      step();
      rld_we = 1'b0;
      half_len(n);
      chk("R4", "current half unchanged by write", n, 2);
      half_len(n);
      chk("R4", "new reload in use", n, 2);
      guard = 0;
      while (m_cnt != 16'h0000 && guard < 100) begin
         step();
         guard++;
      end
      rld_we = 1'b1; rld_wdata = 16'd5;
      step();
      rld_we = 1'b0;
      half_len(n);
      chk("R4", "write on underflow loads old value", n, 2);
      half_len(n);
      chk("R4", "written value used after", n, 6);
      repeat (14) step_cmp("R4");
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; rld_we = 1'b0; rld_wdata = '0;
      out_en = 1'b0; irq_en = 1'b0; pend_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_underflow();
      t_clear();
      t_duty();
      t_gate();
      t_irq_en();
      t_freeze();
      t_set_wins();
      t_reload();
      finish_run();
   end

endmodule